// File: doc/BRIEF.md
# Threshold-Gated Transmit Word Queue

This block buffers outgoing frame data between a DMA fetch engine and a MAC transmitter. The fetch engine pushes 32-bit words that are already aligned to a word boundary. Each word carries a flag that marks the last word of a frame and a 2-bit field that gives the number of valid bytes in that last word. The MAC pops words in arrival order from a show-ahead read port.

The queue counts the bytes it holds, not the words. It asks the MAC to start sending only when that count reaches a programmable threshold, or when a whole frame is already stored. With a threshold of zero it always waits for a complete frame. When the MAC pops the last word of a frame, a one-cycle drained pulse goes back to the fetch engine. A full flag throttles the fetch engine.

Top module: `txq_fifo`

## Requirements
- R1: While reset is low and right after it is released, the queue is empty: `rd_valid`=0, `full`=0, `byte_count`=0, `tx_req`=0, `pkt_drained`=0.
- R2: Words leave in the order they were written. While the queue is not empty, `rd_valid`=1 and `rd_data`, `rd_last` and `rd_nbytes` show the oldest stored word.
- R3: The queue holds 512 words. `full` is 1 exactly when 512 words are stored, and a write attempted while `full` is 1 is dropped.
- R4: A read attempted while the queue is empty has no effect. The queue stays empty and `byte_count` stays 0.
- R5: `byte_count` equals the sum of the byte weights of the stored words. A word weighs 4 bytes, except a word with its last flag set and a nonzero `nbytes` field, which weighs `nbytes` bytes (encoding 01=1, 10=2, 11=3, 00=4).
- R6: With `thresh` nonzero, `tx_req` is 1 whenever `byte_count` >= 16*`thresh`.
- R7: With `thresh` zero, `tx_req` is 1 only while at least one complete frame (a word with its last flag set) is stored.
- R8: While a complete frame is stored, `tx_req` is 1 whatever the threshold, so short frames are not held back.
- R9: `pkt_drained` is 1 for exactly the cycle after each clock edge at which a word with its last flag set is popped.
- R10: A read and a write in the same cycle both take effect. While `full` is 1, only the read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh | input | 7 | Request threshold in 16-byte units; 0 means wait for a whole frame |
| wr_valid | input | 1 | Write strobe from the fetch engine |
| wr_data | input | 32 | Aligned data word |
| wr_last | input | 1 | Marks the final word of a frame |
| wr_nbytes | input | 2 | Valid bytes in a final word (00 means 4) |
| full | output | 1 | Queue holds 512 words; writes are dropped |
| rd_en | input | 1 | Pop strobe from the MAC |
| rd_valid | output | 1 | Queue is not empty |
| rd_data | output | 32 | Oldest stored word |
| rd_last | output | 1 | Last flag of the oldest word |
| rd_nbytes | output | 2 | Byte field of the oldest word |
| byte_count | output | 12 | Bytes currently stored |
| tx_req | output | 1 | Transmit request to the MAC |
| pkt_drained | output | 1 | One-cycle pulse after a frame's last word is popped |

## Verification
The threshold path is driven with a slowly filling run of full words, so the request's first cycle shows whether the 16-byte scaling and the >= comparison are right. Short frames are sent with a threshold of zero and with the largest threshold, which separates the request caused by a complete frame from the request caused by the byte level. The odd final-word byte fields catch weighting errors that a word count would hide. A fill past 512 words, followed by simultaneous pops and pushes and by pops on an empty queue, exercises the full, refusal and empty boundaries. Long random mixed traffic with threshold changes then compares every output against a queue-based model on every clock.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Byte weight of one stored word: a final word with a nonzero field counts that many bytes.
  function automatic logic [2:0] word_bytes(input logic last, input logic [1:0] nb);
    if (last && (nb != 2'b00)) return {1'b0, nb};
    return 3'd4;
  endfunction

  // Threshold field scaled to bytes.
  function automatic logic [15:0] thresh_bytes(input logic [15:0] th, input int unsigned lg2);
    return th << lg2;
  endfunction
endpackage

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
  parameter int DEPTH = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] count_q;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (wr_fire) wr_ptr <= bump(wr_ptr);
      if (rd_fire) rd_ptr <= bump(rd_ptr);
      if (wr_fire && !rd_fire)      count_q <= count_q + 1'b1;
      else if (rd_fire && !wr_fire) count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 35,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int DEPTH    = 512,
  parameter int THR_W    = 7,
  parameter int UNIT_LG2 = 4,
  localparam int BYTE_W  = $clog2(4 * DEPTH + 1),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  thresh,
  input  logic              wr_fire,
  input  logic              wr_last,
  input  logic [1:0]        wr_nb,
  input  logic              rd_fire,
  input  logic              rd_last,
  input  logic [1:0]        rd_nb,
  output logic [BYTE_W-1:0] byte_count,
  output logic [CNT_W-1:0]  pkts_resident,
  output logic              level_hit,
  output logic              tx_req,
  output logic              pkt_drained
);
  import txq_pkg::*;

  logic [BYTE_W-1:0] add_b, sub_b;
  logic              add_p, sub_p;

  assign add_b = wr_fire ? BYTE_W'(word_bytes(wr_last, wr_nb)) : '0;
  assign sub_b = rd_fire ? BYTE_W'(word_bytes(rd_last, rd_nb)) : '0;
  assign add_p = wr_fire && wr_last;
  assign sub_p = rd_fire && rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_count    <= '0;
      pkts_resident <= '0;
      pkt_drained   <= 1'b0;
    end else begin
      byte_count  <= byte_count + add_b - sub_b;
      pkt_drained <= sub_p;
      if (add_p && !sub_p)      pkts_resident <= pkts_resident + 1'b1;
      else if (sub_p && !add_p) pkts_resident <= pkts_resident - 1'b1;
    end
  end

  assign level_hit = (thresh != '0) &&
                     (16'(byte_count) >= thresh_bytes(16'(thresh), UNIT_LG2));
  assign tx_req    = level_hit || (pkts_resident != '0);
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH    = 512,
  parameter int DATA_W   = 32,
  parameter int THR_W    = 7,
  parameter int UNIT_LG2 = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [THR_W-1:0]               thresh,
  input  logic                           wr_valid,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           wr_last,
  input  logic [1:0]                     wr_nbytes,
  output logic                           full,
  input  logic                           rd_en,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_last,
  output logic [1:0]                     rd_nbytes,
  output logic [$clog2(4*DEPTH+1)-1:0]   byte_count,
  output logic                           tx_req,
  output logic                           pkt_drained
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = DATA_W + 3;

  logic             wr_fire, rd_fire, empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] ent_in, ent_out;
  logic [CNT_W-1:0] pkts_resident;
  logic             level_hit;
  logic             pop_last;

  txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_valid), .rd_req(rd_en),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty)
  );

  assign ent_in = {wr_last, wr_nbytes, wr_data};

  txq_mem #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(ent_in),
    .raddr(rd_ptr), .rdata(ent_out)
  );

  assign rd_valid  = !empty;
  assign rd_data   = ent_out[DATA_W-1:0];
  assign rd_nbytes = ent_out[DATA_W+1:DATA_W];
  assign rd_last   = ent_out[DATA_W+2];
  assign pop_last  = rd_fire && rd_last;

  txq_level #(.DEPTH(DEPTH), .THR_W(THR_W), .UNIT_LG2(UNIT_LG2)) u_level (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .wr_fire(wr_fire), .wr_last(wr_last), .wr_nb(wr_nbytes),
    .rd_fire(rd_fire), .rd_last(rd_last), .rd_nb(rd_nbytes),
    .byte_count(byte_count), .pkts_resident(pkts_resident),
    .level_hit(level_hit), .tx_req(tx_req), .pkt_drained(pkt_drained)
  );
endmodule

// File: rtl/txq_fifo_chk.sv
module txq_fifo_chk #(
  parameter int DEPTH    = 512,
  parameter int THR_W    = 7,
  parameter int UNIT_LG2 = 4,
  localparam int BYTE_W  = $clog2(4 * DEPTH + 1),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [THR_W-1:0]  thresh,
  input logic              wr_valid,
  input logic              rd_en,
  input logic              full,
  input logic              rd_valid,
  input logic [BYTE_W-1:0] byte_count,
  input logic [CNT_W-1:0]  pkts_resident,
  input logic              tx_req,
  input logic              pkt_drained,
  input logic              pop_last
);
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (byte_count == '0 && !rd_valid && !full));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> (full && $stable(byte_count)));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_valid) |=> (!rd_valid && byte_count == '0));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(byte_count) <= 4 * DEPTH));

  p_level_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh != '0 && (32'(byte_count) >= (32'(thresh) << UNIT_LG2))) |-> tx_req);

  p_whole_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0 && tx_req) |-> (pkts_resident != '0));

  p_frame_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkts_resident != '0) |-> tx_req);

  p_drain_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_last |=> pkt_drained);

  p_drain_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drained |-> $past(pop_last));
endmodule

bind txq_fifo txq_fifo_chk #(.DEPTH(DEPTH), .THR_W(THR_W), .UNIT_LG2(UNIT_LG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .thresh(thresh), .wr_valid(wr_valid), .rd_en(rd_en),
  .full(full), .rd_valid(rd_valid), .byte_count(byte_count),
  .pkts_resident(pkts_resident), .tx_req(tx_req), .pkt_drained(pkt_drained),
  .pop_last(pop_last)
);

// File: tb/test_txq_fifo.sv
`timescale 1ns/1ps
module test_txq_fifo;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  thresh = 7'd0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_last = 1'b0;
  logic [1:0]  wr_nbytes = 2'b00;
  logic        rd_en = 1'b0;
  logic        full, rd_valid, rd_last, tx_req, pkt_drained;
  logic [31:0] rd_data;
  logic [1:0]  rd_nbytes;
  logic [11:0] byte_count;

  always #2.5 clk = ~clk;

  txq_fifo i_txq_fifo (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_last(wr_last), .wr_nbytes(wr_nbytes), .full(full),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .rd_nbytes(rd_nbytes), .byte_count(byte_count), .tx_req(tx_req),
    .pkt_drained(pkt_drained)
  );

  typedef struct { logic [31:0] d; bit l; bit [1:0] b; } ent_t;
  ent_t  mq[$];
  int    m_bytes = 0;
  int    m_pkts  = 0;
  bit    m_drain = 1'b0;
  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R2";
  bit    done = 1'b0;

  function automatic int weight(bit l, bit [1:0] b);
    return (l && b != 0) ? int'(b) : 4;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Reference model: updated on each rising edge from the inputs alone.
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_bytes = 0; m_pkts = 0; m_drain = 1'b0;
    end else begin
      bit dr, dw;
      dr = rd_en && (mq.size() > 0);
      dw = wr_valid && (mq.size() < DEPTH);
      m_drain = 1'b0;
      if (dr) begin
        ent_t e;
        e = mq.pop_front();
        m_bytes -= weight(e.l, e.b);
        if (e.l) begin m_pkts--; m_drain = 1'b1; end
      end
      if (dw) begin
        ent_t n;
        n.d = wr_data; n.l = wr_last; n.b = wr_nbytes;
        mq.push_back(n);
        m_bytes += weight(wr_last, wr_nbytes);
        if (wr_last) m_pkts++;
      end
    end
  end

  // Compare on every falling edge; inputs change 1 ns later.
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "byte_count in reset", int'(byte_count), 0);
      chk("R1", "rd_valid in reset", int'(rd_valid), 0);
      chk("R1", "tx_req in reset", int'(tx_req), 0);
      chk("R1", "full in reset", int'(full), 0);
    end else if (!done) begin
      bit exp_req;
      string rq;
      exp_req = (m_pkts > 0) || (thresh != 0 && m_bytes >= int'(thresh) * 16);
      rq = (m_pkts > 0) ? "R8" : ((thresh == 0) ? "R7" : "R6");
      chk(rq, "tx_req", int'(tx_req), int'(exp_req));
      chk("R3", "full", int'(full), int'(mq.size() == DEPTH));
      chk({"R2/", tag}, "rd_valid", int'(rd_valid), int'(mq.size() > 0));
      chk({"R5/", tag}, "byte_count", int'(byte_count), m_bytes);
      chk("R9", "pkt_drained", int'(pkt_drained), int'(m_drain));
      if (mq.size() > 0) begin
        chk({"R2/", tag}, "rd_data", int'(rd_data), int'(mq[0].d));
        chk("R2", "rd_last", int'(rd_last), int'(mq[0].l));
        chk("R2", "rd_nbytes", int'(rd_nbytes), int'(mq[0].b));
      end
    end
  end

  task automatic drive(bit wv, bit l, bit [1:0] b, bit re);
    @(negedge clk); #1;
    wr_valid = wv; wr_data = $urandom; wr_last = l; wr_nbytes = b; rd_en = re;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2: actual hung expected finished");
    finish_run();
  end

  initial begin
    thresh = 7'd2;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R6: 32-byte threshold reached on the eighth full word.
    tag = "R6";
    for (int i = 0; i < 8; i++) drive(1, 0, 2'b00, 0);
    drive(1, 1, 2'b01, 0);           // last word weighs 1 byte
    drive(0, 0, 2'b00, 0);
    for (int i = 0; i < 12; i++) drive(0, 0, 2'b00, 1);
    drive(0, 0, 2'b00, 0);

    // R7: zero threshold waits for the final word.
    tag = "R7"; thresh = 7'd0;
    for (int i = 0; i < 3; i++) drive(1, 0, 2'b00, 0);
    drive(0, 0, 2'b00, 0);
    drive(1, 1, 2'b11, 0);
    drive(0, 0, 2'b00, 0);
    for (int i = 0; i < 6; i++) drive(0, 0, 2'b00, 1);

    // R8: short frame under the largest threshold.
    tag = "R8"; thresh = 7'd127;
    drive(1, 0, 2'b00, 0);
    drive(1, 1, 2'b10, 0);
    drive(0, 0, 2'b00, 0);
    drive(1, 1, 2'b00, 1);           // R10 read and write together
    for (int i = 0; i < 4; i++) drive(0, 0, 2'b00, 1);

    // R3: fill past capacity.
    tag = "R3";
    for (int i = 0; i < DEPTH + 8; i++) drive(1, 0, 2'b00, 0);
    drive(0, 0, 2'b00, 0);
    @(negedge clk);
    chk("R3", "full after overfill", int'(full), 1);
    chk("R3", "byte_count after overfill", int'(byte_count), 4 * DEPTH);

    // R10: push and pop while full, then while not full.
    tag = "R10";
    for (int i = 0; i < 6; i++) drive(1, i == 5, 2'b00, 1);
    drive(0, 0, 2'b00, 0);

    // R4: drain and keep popping an empty queue.
    tag = "R4";
    for (int i = 0; i < DEPTH + 10; i++) drive(0, 0, 2'b00, 1);
    drive(0, 0, 2'b00, 0);
    @(negedge clk);
    chk("R4", "byte_count after empty pops", int'(byte_count), 0);
    chk("R4", "rd_valid after empty pops", int'(rd_valid), 0);

    // Mixed random traffic.
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        @(negedge clk); #1;
        thresh = ($urandom % 4 == 0) ? 7'd0 : 7'($urandom % 128);
      end
      drive(($urandom % 10) < 6, ($urandom % 6) == 0, 2'($urandom), ($urandom % 2) == 1);
    end
    drive(0, 0, 2'b00, 0);
    @(negedge clk);
    finish_run();
  end
endmodule